// File: doc/BRIEF.md
# Subtractive GCD Engine with One-Hot Statement Control

This block computes the greatest common divisor of two unsigned operands. It runs a short fixed program: load both operands, then loop while the two values differ. On each pass the larger value has the smaller one subtracted from it. The hardware has the shape a straightforward language-to-gates translation gives. Each program variable is a register. Each expression is combinational logic. A variable written by two statements takes its next value through a multiplexer steered by whichever statement is active.

Sequencing uses no encoded state machine. Every assignment statement owns a start token and a finish token, and the finish token is the start token delayed by one clock. The finish tokens of the load and subtract statements are OR-ed into a single loop-test point. There the comparison routes the token to exactly one of three places: the subtract-from-a statement, the subtract-from-b statement or the loop exit. The exit token becomes a one-cycle completion pulse.

A caller raises `start` for one cycle with the operands present. It then waits for `done` and reads `result`. A start that arrives while a computation is in flight has no effect.

Top module: `gcd_onehot_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, every token clears, `a` and `b` clear to 0 and `done` is 0 after that edge. A loop that never ends (one operand 0, the other nonzero) is left only through this reset.
- R2: `start` sampled high while idle loads `a_in` into `a` and `b_in` into `b` at that edge. This load is one statement that takes one cycle.
- R3: With N subtraction steps needed, `done` is high exactly in the cycle after the (N+1)th rising edge that follows the edge which accepted `start`. Each statement therefore costs one cycle, and equal operands give N = 0.
- R4: When the loop test sees a > b, the following edge replaces a with a − b and leaves b unchanged.
- R5: When the loop test sees a < b, the following edge replaces b with b − a and leaves a unchanged.
- R6: `done` is a single-cycle pulse. In that cycle `result` equals the GCD of the nonzero operands (0 when both are 0), and `result` holds that value until the next accepted start.
- R7: `start` raised while a computation is in flight is ignored. The running computation finishes at the same cycle with the same `result`.
- R8: At most one statement start token is active in any cycle.
- R9: The cycle in which `done` is high counts as idle, so a `start` there is accepted and begins a new computation at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single global clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to begin a computation, sampled at the rising edge |
| a_in | input | WIDTH | First operand, captured with an accepted start |
| b_in | input | WIDTH | Second operand, captured with an accepted start |
| done | output | 1 | One-cycle pulse at loop exit |
| result | output | WIDTH | Current value of variable a; the GCD once `done` pulses |

## Verification
For each operand pair the bench counts the subtraction steps N. It expects `done` to be low after edges 1 to N following the accepting edge, high after edge N+1, and low again after edge N+2. Inputs are driven and outputs sampled on falling edges, so each check reads a value that has settled one half period after the edge it belongs to. An intruding start is placed at a chosen edge inside that window, and a chained start is placed in the `done` cycle itself. Both are checked against the same edge-counted schedule.

// File: rtl/gcd_seq_pkg.sv
// Package: shared statement indices for the one-hot GCD sequencer.
// Assumes: the three statements are enumerated densely from 0.
package gcd_seq_pkg;

    // Identifies each assignment statement of the program
    typedef enum int {
        STMT_LOAD = 0,
        STMT_SUBA = 1,
        STMT_SUBB = 2
    } stmt_e;

    localparam int NUM_STMT = 3;

endpackage

// File: rtl/stmt_token.sv
// Module: stmt_token
// One assignment statement's control cell. A start token in cycle t gives
// the finish token in cycle t+1, so every statement costs one cycle.
// Assumes: start is a single-cycle pulse from the surrounding control.
module stmt_token (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic finish
);

    // Delay the start token by one cycle to form the finish token
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            finish <= 1'b0;
        end else begin
            finish <= start;
        end
    end

endmodule

// File: rtl/var_reg.sv
// Module: var_reg
// A program variable held in a register. Each writing statement supplies a
// source value and its start token; the active token picks the source
// through an AND-OR multiplexer and enables the load.
// Assumes: at most one bit of sel is set in any cycle.
module var_reg #(
    parameter int WIDTH = 16,
    parameter int NSRC  = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NSRC-1:0]             sel,
    input  logic [NSRC-1:0][WIDTH-1:0]  src,
    output logic [WIDTH-1:0]            q
);

    logic [WIDTH-1:0] nxt;
    logic             en;

    // Select the source of the one active statement
    always_comb begin
        nxt = '0;
        for (int i = 0; i < NSRC; i++) begin
            nxt = nxt | (src[i] & {WIDTH{sel[i]}});
        end
        en = |sel;
    end

    // Hold the value unless a writing statement is active
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (en) begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/loop_test.sv
// Module: loop_test
// The while-loop test and the if-else inside it. An incoming token goes to
// exactly one of three outputs: subtract-from-a, subtract-from-b or exit.
// Assumes: eval is a single token formed by OR-ing the join finishes.
module loop_test #(
    parameter int WIDTH = 16
) (
    input  logic             eval,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic             go_suba,
    output logic             go_subb,
    output logic             leave
);

    logic differ;
    logic a_big;

    // Evaluate the conditions and steer the token
    always_comb begin
        differ  = (a != b);
        a_big   = (a > b);
        go_suba = eval & differ & a_big;
        go_subb = eval & differ & ~a_big;
        leave   = eval & ~differ;
    end

endmodule

// File: rtl/gcd_onehot_seq.sv
// Module: gcd_onehot_seq
// Subtractive GCD built as a datapath plus a chain of statement tokens.
// Program: a=a_in; b=b_in; while (a!=b) { if (a>b) a=a-b; else b=b-a; }
// Busy whenever a finish token is alive; a start while busy is dropped.
// Assumes: one synchronous clock; operands both nonzero or both zero,
// otherwise the loop runs until reset.
module gcd_onehot_seq #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic             done,
    output logic [WIDTH-1:0] result
);

    import gcd_seq_pkg::*;

    logic [NUM_STMT-1:0] st_tok;
    logic [NUM_STMT-1:0] fin_tok;
    logic [WIDTH-1:0]    a_q;
    logic [WIDTH-1:0]    b_q;
    logic                busy;
    logic                join_tok;
    logic                go_suba;
    logic                go_subb;
    logic                leave;

    // Form the start tokens: load from the caller, others from the test
    always_comb begin
        busy             = |fin_tok;
        join_tok         = fin_tok[STMT_LOAD] | fin_tok[STMT_SUBA] | fin_tok[STMT_SUBB];
        st_tok           = '0;
        st_tok[STMT_LOAD] = start & ~busy;
        st_tok[STMT_SUBA] = go_suba;
        st_tok[STMT_SUBB] = go_subb;
    end

    // One control cell per statement
    for (genvar s = 0; s < NUM_STMT; s++) begin : g_stmt
        stmt_token u_tok (
            .clk    (clk),
            .rst_n  (rst_n),
            .start  (st_tok[s]),
            .finish (fin_tok[s])
        );
    end

    loop_test #(.WIDTH(WIDTH)) u_test (
        .eval    (join_tok),
        .a       (a_q),
        .b       (b_q),
        .go_suba (go_suba),
        .go_subb (go_subb),
        .leave   (leave)
    );

    // Variable a: written by the load and by a = a - b
    var_reg #(.WIDTH(WIDTH), .NSRC(2)) u_var_a (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   ({st_tok[STMT_SUBA], st_tok[STMT_LOAD]}),
        .src   ({a_q - b_q, a_in}),
        .q     (a_q)
    );

    // Variable b: written by the load and by b = b - a
    var_reg #(.WIDTH(WIDTH), .NSRC(2)) u_var_b (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   ({st_tok[STMT_SUBB], st_tok[STMT_LOAD]}),
        .src   ({b_q - a_q, b_in}),
        .q     (b_q)
    );

    // Register the exit token as the completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= leave;
        end
    end

    assign result = a_q;

endmodule

// File: rtl/gcd_seq_checker.sv
// Module: gcd_seq_checker
// Property checks for gcd_onehot_seq, attached by the bind below.
// Assumes: it sees the top's statement tokens and variables.
module gcd_seq_checker #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] b_in,
    input logic             done,
    input logic [WIDTH-1:0] result,
    input logic [2:0]       st,
    input logic [2:0]       fin,
    input logic [WIDTH-1:0] a_q,
    input logic [WIDTH-1:0] b_q
);

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (fin == 3'b000 && !done && a_q == '0 && b_q == '0)); // R1

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n) st[0] |=> (a_q == $past(a_in) && b_q == $past(b_in))); // R2

    AST_SUBA_STEP: assert property (@(posedge clk) disable iff (!rst_n) st[1] |=> (a_q == $past(a_q) - $past(b_q) && $stable(b_q))); // R4

    AST_SUBB_STEP: assert property (@(posedge clk) disable iff (!rst_n) st[2] |=> (b_q == $past(b_q) - $past(a_q) && $stable(a_q))); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R6

    AST_DONE_EQUAL: assert property (@(posedge clk) disable iff (!rst_n) done |-> (result == b_q)); // R6

    AST_BUSY_DROPS_START: assert property (@(posedge clk) disable iff (!rst_n) (|fin) |=> !fin[0]); // R7

    AST_START_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(st)); // R8

    AST_IDLE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) (start && fin == 3'b000) |=> fin[0]); // R9

endmodule

bind gcd_onehot_seq gcd_seq_checker #(.WIDTH(WIDTH)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .a_in   (a_in),
    .b_in   (b_in),
    .done   (done),
    .result (result),
    .st     (st_tok),
    .fin    (fin_tok),
    .a_q    (a_q),
    .b_q    (b_q)
);

// File: tb/sim_gcd_onehot_seq.sv
// Directed bench for gcd_onehot_seq: inputs change and outputs are read
// on falling edges; each scenario task checks its own results.
module sim_gcd_onehot_seq;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic         done;
    logic [W-1:0] result;

    int checks = 0;
    int failures = 0;

    gcd_onehot_seq #(.WIDTH(W)) u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .a_in   (a_in),
        .b_in   (b_in),
        .done   (done),
        .result (result)
    );

    always #5 clk = ~clk;

    // Record one check; print a FAIL line on mismatch
    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Number of subtraction steps the program performs
    function automatic int steps(input int a, input int b);
        int n = 0;
        while (a != b && n < 10000) begin
            if (a > b) a = a - b; else b = b - a;
            n++;
        end
        return n;
    endfunction

    function automatic int gcd_of(input int a, input int b);
        while (a != b) begin
            if (a > b) a = a - b; else b = b - a;
        end
        return a;
    endfunction

    // Drive a start request at the current falling edge
    task automatic launch(input int a, input int b);
        start = 1'b1;
        a_in  = W'(a);
        b_in  = W'(b);
    endtask

    // Follow one computation launched at this falling edge. Optionally
    // inject a start at edge intr_k, or chain a new start in the done cycle.
    task automatic track(input int a, input int b, input int intr_k, input int ia, input int ib,
                         input bit chain, input int ca, input int cb, input string req);
        int n = steps(a, b);
        int g = gcd_of(a, b);
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, "R3 done low after accepting edge", done, 0);
        for (int k = 1; k <= n + 1; k++) begin
            @(negedge clk);
            start = 1'b0;
            if (k <= n && done) check(1'b0, {req, " R3 early done"}, k, n + 1);
            if (k == intr_k && k <= n) launch(ia, ib);
        end
        check(done == 1'b1, {req, " R3 done at edge N+1"}, done, 1);
        check(result == W'(g), {req, " R6 result is gcd"}, result, g);
        if (chain) begin
            launch(ca, cb);
        end else begin
            @(negedge clk);
            check(done == 1'b0, {req, " R6 done single pulse"}, done, 0);
            check(result == W'(g), {req, " R6 result held"}, result, g);
        end
    endtask

    // Scenario: reset state
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(done == 1'b0, "R1 done after reset", done, 0);
        check(result == '0, "R1 result after reset", result, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Scenario: basic computations over several operand patterns
    task automatic t_basic();
        launch(9, 9);   track(9, 9, 0, 0, 0, 0, 0, 0, "R3 equal operands");
        launch(0, 0);   track(0, 0, 0, 0, 0, 0, 0, 0, "R6 both zero");
        launch(20, 6);  track(20, 6, 0, 0, 0, 0, 0, 0, "R4 a larger first");
        launch(6, 20);  track(6, 20, 0, 0, 0, 0, 0, 0, "R5 b larger first");
        launch(13, 8);  track(13, 8, 0, 0, 0, 0, 0, 0, "R4 R5 coprime");
        launch(1, 255); track(1, 255, 0, 0, 0, 0, 0, 0, "R5 long loop");
        launch(48, 18); track(48, 18, 0, 0, 0, 0, 0, 0, "R2 mixed");
    endtask

    // Scenario: a start while busy is ignored
    task automatic t_busy();
        launch(20, 6); track(20, 6, 2, 9, 3, 0, 0, 0, "R7 start mid loop");
        launch(35, 14); track(35, 14, 1, 4, 4, 0, 0, 0, "R7 start right after load");
    endtask

    // Scenario: a start in the done cycle is accepted at once
    task automatic t_chain();
        launch(12, 18); track(12, 18, 0, 0, 0, 1, 7, 21, "R9 first of chain");
        track(7, 21, 0, 0, 0, 0, 0, 0, "R9 chained start");
    endtask

    // Scenario: a non-ending loop is cleared by reset
    task automatic t_hang();
        bit seen = 1'b0;
        launch(0, 5);
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (done) seen = 1'b1;
        end
        check(seen == 1'b0, "R1 zero operand never finishes", seen, 0);
        rst_n = 1'b0;
        @(negedge clk);
        check(done == 1'b0 && result == '0, "R1 reset clears hung loop", result, 0);
        rst_n = 1'b1;
        @(negedge clk);
        launch(21, 14); track(21, 14, 0, 0, 0, 0, 0, 0, "R1 recovery after reset");
    endtask

    // Watchdog: a hung run is a failure but still reports
    initial begin
        #2000000;
        failures++;
        $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_basic();
        t_busy();
        t_chain();
        t_hang();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule